// File: doc/BRIEF.md
# Line-Slotted Memory Access Scheduler

The scheduler shares one single-port page memory among the functions of a teletext decoder by cutting each 64 µs television line into 128 fixed time slots of 500 ns. Each slot is three cycles of the 6 MHz base clock. The slots alternate between write and read, so every line carries 64 write slots and 64 read slots. Every slot has a fixed owner, and the owner gets its grant with no arbitration.

On the write side, a 60-slot acquisition window takes the incoming character stream. The window is wide enough for 40 to 42 characters, covering about 46 µs of data plus a small timing tolerance. After the window come a host write slot, a slot that sets the page-found flag, and a slot that writes the header colour code into row 0, column 7. The last write slot is idle.

On the read side, 40 slots fetch display characters and two slots serve host reads. The other read slots are idle. An acquisition request that falls outside its window gets no grant, and a saturating counter records it. A line-sync pulse realigns the slot counter to slot 0.

Top module: `line_slot_sched`

## Requirements
- R1: After reset, slot_o is 0, rd_phase_o is 0, no grant other than a requested acquisition grant is high, and drop_cnt_o is 0.
- R2: Each slot lasts exactly 3 clock cycles. slot_o then advances by one, and wraps from 127 to 0.
- R3: When line_sync_i is high at a rising edge, the next cycle is the first cycle of slot 0, whatever slot or cycle came before.
- R4: rd_phase_o is 0 in even slots (write) and 1 in odd slots (read).
- R5: gnt_disp_o is high throughout the odd slots 1, 3, ... 79, which are read indices 0 to 39, with read index = slot/2.
- R6: gnt_hrd_o is high in read slots 81 and 83. Odd slots 85 to 127 raise no grant.
- R7: In the even slots 0 to 118 (the acquisition window), gnt_acq_o equals acq_req_i in every cycle.
- R8: gnt_hwr_o is high in slot 120, gnt_flag_o in slot 122 and gnt_col_o in slot 124. Slot 126 raises no grant.
- R9: A cycle with acq_req_i high outside the acquisition window (any odd slot, or even slots 120 to 126) raises no gnt_acq_o and adds one to drop_cnt_o on the next edge. The count saturates at 2^CNT_W-1, which is 255 by default.
- R10: At most one grant output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 6 MHz base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_sync_i | input | 1 | Line-start pulse, restarts slot counting |
| acq_req_i | input | 1 | Acquisition character write request, one cycle per character |
| slot_o | output | 7 | Current slot index within the line |
| rd_phase_o | output | 1 | 1 in read slots, 0 in write slots |
| gnt_acq_o | output | 1 | Acquisition write granted this cycle |
| gnt_disp_o | output | 1 | Display read slot |
| gnt_hrd_o | output | 1 | Host read slot |
| gnt_hwr_o | output | 1 | Host write slot |
| gnt_flag_o | output | 1 | Page-found flag write slot |
| gnt_col_o | output | 1 | Header colour code write slot |
| drop_cnt_o | output | 8 | Saturating count of dropped acquisition requests |

## Verification
Several rules are checked by assertions on every cycle:
- the slot length and the slot held steady between boundaries;
- the restart one cycle after sync;
- the rule that acquisition grants fall only in write slots;
- the one-hot grant set;
- the counter's step and saturation.

Other behaviour can only be shown by the bench's scenarios: the full slot-to-owner map, the wrap from 127 to 0, sync pulses landing in arbitrary slots, and drops in both read slots and the tail of the write slots. The bench compares every output on every cycle against its own model of the line.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [2:0] {
    K_ACQ, K_DISP, K_HRD, K_HWR, K_FLAG, K_COL, K_IDLE
  } slot_kind_e;
endpackage

// File: rtl/lss_slot_timer.sv
module lss_slot_timer #(
  parameter int CYC_PER_SLOT = 3,
  parameter int SLOTS        = 128,
  localparam int SLOT_W      = $clog2(SLOTS),
  localparam int PH_W        = $clog2(CYC_PER_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [PH_W-1:0]   phase_o
);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(CYC_PER_SLOT - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [PH_W-1:0]   phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      phase_q <= '0;
    end else if (sync_i) begin
      slot_q  <= '0;
      phase_q <= '0;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
      slot_q  <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign slot_o  = slot_q;
  assign phase_o = phase_q;

  a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= PH_LAST);
  a_r2_slot_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_LAST && !sync_i) |=> $stable(slot_q));
  a_r3_sync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (slot_q == '0 && phase_q == '0));
endmodule

// File: rtl/lss_slot_decode.sv
module lss_slot_decode
  import lss_pkg::*;
#(
  parameter int SLOTS     = 128,
  parameter int ACQ_SLOTS = 60,
  parameter int DISP_SLOTS = 40,
  parameter int HRD_SLOTS = 2,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int IDX_W    = SLOT_W - 1
) (
  input  logic [SLOT_W-1:0] slot_i,
  output slot_kind_e        kind_o,
  output logic              rd_o
);
  logic [IDX_W-1:0] idx;
  int               i;

  assign idx  = slot_i[SLOT_W-1:1];
  assign rd_o = slot_i[0];
  assign i    = int'(idx);

  always_comb begin
    kind_o = K_IDLE;
    if (rd_o) begin
      if (i < DISP_SLOTS)                  kind_o = K_DISP;
      else if (i < DISP_SLOTS + HRD_SLOTS) kind_o = K_HRD;
    end else begin
      if (i < ACQ_SLOTS)                   kind_o = K_ACQ;
      else if (i == ACQ_SLOTS)             kind_o = K_HWR;
      else if (i == ACQ_SLOTS + 1)         kind_o = K_FLAG;
      else if (i == ACQ_SLOTS + 2)         kind_o = K_COL;
    end
  end

  always_comb begin
    a_r4_acq_in_write: assert (!(kind_o == K_ACQ && rd_o));
    a_r5_disp_in_read: assert (!(kind_o == K_DISP && !rd_o));
  end
endmodule

// File: rtl/lss_drop_counter.sv
module lss_drop_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  a_r9_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/line_slot_sched.sv
module line_slot_sched
  import lss_pkg::*;
#(
  parameter int CYC_PER_SLOT = 3,
  parameter int SLOTS        = 128,
  parameter int ACQ_SLOTS    = 60,
  parameter int DISP_SLOTS   = 40,
  parameter int HRD_SLOTS    = 2,
  parameter int CNT_W        = 8,
  localparam int SLOT_W      = $clog2(SLOTS),
  localparam int PH_W        = $clog2(CYC_PER_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_sync_i,
  input  logic              acq_req_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              rd_phase_o,
  output logic              gnt_acq_o,
  output logic              gnt_disp_o,
  output logic              gnt_hrd_o,
  output logic              gnt_hwr_o,
  output logic              gnt_flag_o,
  output logic              gnt_col_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  logic [SLOT_W-1:0] slot;
  logic [PH_W-1:0]   phase;
  slot_kind_e        kind;
  logic              rd;
  logic              drop;

  lss_slot_timer #(.CYC_PER_SLOT(CYC_PER_SLOT), .SLOTS(SLOTS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(line_sync_i),
    .slot_o(slot), .phase_o(phase)
  );

  lss_slot_decode #(
    .SLOTS(SLOTS), .ACQ_SLOTS(ACQ_SLOTS),
    .DISP_SLOTS(DISP_SLOTS), .HRD_SLOTS(HRD_SLOTS)
  ) u_decode (
    .slot_i(slot), .kind_o(kind), .rd_o(rd)
  );

  assign drop = acq_req_i && kind != K_ACQ;

  lss_drop_counter #(.CNT_W(CNT_W)) u_drop (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(drop), .cnt_o(drop_cnt_o)
  );

  assign slot_o     = slot;
  assign rd_phase_o = rd;
  assign gnt_acq_o  = kind == K_ACQ && acq_req_i;
  assign gnt_disp_o = kind == K_DISP;
  assign gnt_hrd_o  = kind == K_HRD;
  assign gnt_hwr_o  = kind == K_HWR;
  assign gnt_flag_o = kind == K_FLAG;
  assign gnt_col_o  = kind == K_COL;

  logic unused_phase;
  assign unused_phase = ^phase;

  a_r10_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gnt_acq_o, gnt_disp_o, gnt_hrd_o, gnt_hwr_o, gnt_flag_o, gnt_col_o}));
  a_r7_acq_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_acq_o |-> !rd_phase_o);
  a_r4_read_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_disp_o || gnt_hrd_o) |-> rd_phase_o);
endmodule

// File: tb/line_slot_sched_tb.sv
module line_slot_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic       req = 1'b0;
  logic [6:0] slot;
  logic       rd;
  logic       g_acq, g_disp, g_hrd, g_hwr, g_flag, g_col;
  logic [7:0] cnt;

  int n_chk = 0;
  int n_bad = 0;
  int m_slot = 0;
  int m_ph = 0;
  int m_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_slot_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_sync_i(sync), .acq_req_i(req),
    .slot_o(slot), .rd_phase_o(rd), .gnt_acq_o(g_acq), .gnt_disp_o(g_disp),
    .gnt_hrd_o(g_hrd), .gnt_hwr_o(g_hwr), .gnt_flag_o(g_flag),
    .gnt_col_o(g_col), .drop_cnt_o(cnt)
  );

  // grant vector {acq,disp,hrd,hwr,flag,col}
  function automatic logic [5:0] exp_gnt(int s, bit r);
    int w = s / 2;
    if (s % 2 == 1) begin
      if (w < 40) return 6'b010000;
      if (w < 42) return 6'b001000;
      return 6'b0;
    end
    if (w < 60) return r ? 6'b100000 : 6'b0;
    if (w == 60) return 6'b000100;
    if (w == 61) return 6'b000010;
    if (w == 62) return 6'b000001;
    return 6'b0;
  endfunction

  function automatic bit in_win(int s);
    return (s % 2 == 0) && (s / 2 < 60);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s slot=%0d ph=%0d act=%0d exp=%0d", tag, m_slot, m_ph, act, exp);
    end
  endtask

  task automatic step();
    logic [5:0] e;
    #1;
    chk("R2 slot", int'(slot), m_slot);
    chk("R4 rd_phase", int'(rd), m_slot % 2);
    e = exp_gnt(m_slot, req);
    chk(m_slot % 2 ? "R5/R6 read grants" : "R7/R8 write grants",
        int'({g_acq, g_disp, g_hrd, g_hwr, g_flag, g_col}), int'(e));
    chk("R10 onehot", int'($countones({g_acq, g_disp, g_hrd, g_hwr, g_flag, g_col}) <= 1), 1);
    chk("R9 drop count", int'(cnt), m_cnt);
    if (req && !in_win(m_slot) && m_cnt < 255) m_cnt++;
    if (sync) begin
      m_slot = 0; m_ph = 0;
    end else if (m_ph == 2) begin
      m_ph = 0; m_slot = (m_slot + 1) % 128;
    end else m_ph++;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (2) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 slot", int'(slot), 0);
    chk("R1 rd", int'(rd), 0);
    chk("R1 grants", int'({g_disp, g_hrd, g_hwr, g_flag, g_col}), 0);
    chk("R1 count", int'(cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // one clean line, no requests: R2 wrap, R5, R6, R8
    for (int k = 0; k < 128 * 3 + 6; k++) begin
      sync = 0; req = 0; step();
    end
    // R3 directed: sync mid-slot
    for (int k = 0; k < 100; k++) begin
      sync = (k == 40); req = 0; step();
    end
    // random: R7 window grants, R9 drops, R3 random sync
    for (int k = 0; k < 1500; k++) begin
      sync = ($urandom % 400) == 0;
      req  = ($urandom % 8) == 0;
      step();
    end
    // R9 saturation: hold request
    for (int k = 0; k < 1200; k++) begin
      sync = 0; req = 1; step();
    end
    // R3 sync on last cycle of slot 127
    while (!(m_slot == 127 && m_ph == 2)) begin
      sync = 0; req = 0; step();
    end
    sync = 1; step();
    for (int k = 0; k < 30; k++) begin
      sync = 0; req = ($urandom % 2) == 1; step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule